// File: doc/BRIEF.md
# Sequence Checker with Status Register

This block receives one or more streams of data words and verifies that each stream carries a known test sequence: either a counter or a pseudo-random word sequence. The checker needs no seed from software. It takes the first valid word it receives after being enabled as the starting point, and it predicts every later word from that one. Each stream is checked on its own. Every stream has its own control word and its own status word.

The data bus may be wider than the sequence. In that case the bits above the sequence width must carry the sequence value repeated, cut off at the top of the bus. Both the low part and the repeated upper part are compared.

Software works through a small register bus on a control clock. The data path runs on a separate, faster data clock. Control bits cross into the data clock domain through two-flop synchronizers, and status bits cross back the same way. The status word tells two cases apart: no result yet, and errors seen. The error flag is sticky. It stays set until checking is re-armed.

Top module: `seq_checker`

## Requirements
- R1: Each stream has a control word at register address 2*s. Bit 0 enables checking. Bit 1 selects the pattern: 0 is pseudo-random and 1 is counter. These two bits read back as written, and all other bits read as 0. A read returns its data in `reg_rdata` on the control clock edge that follows the edge sampling `reg_rd`.
- R2: Each stream has a read-only status word at address 2*s+1. Bit 0 means data errors were seen. Bit 1 means there is no valid result. Bits 31..2 read as 0. A write to this address changes nothing.
- R3: While a stream's checking is disabled, its status reads 2'b10. This is also the state after reset.
- R4: When checking is enabled and the incoming data follows the selected pattern, the status reads 2'b00. The counter successor is v+1, modulo 2^SEQ_W. The pseudo-random successor is {v[30:0], v[31]^v[21]^v[1]^v[0]}.
- R5: When checking is enabled and the incoming data follows the other pattern, the status reads 2'b01.
- R6: A single word corrupted in its low SEQ_W bits sets error bit 0. A single word corrupted only in a replicated upper bit (bit SEQ_W and above, expected equal to bit i mod SEQ_W) also sets it.
- R7: The error bit is sticky. It still reads 1 hundreds of cycles after the bad word.
- R8: A rising edge of enable, or a pattern change while enabled, re-arms the checker. Re-arming clears the error bit, sets the no-result bit, and forgets the seed.
- R9: The first valid word after re-arming seeds the expected value and is not compared. The no-result bit clears once a later valid word has been compared. If no word arrives, the status stays 2'b10.
- R10: Streams are independent. An error, a pattern setting or a missing data flow on one stream leaves the other stream's status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_clk | input | 1 | Register bus clock |
| ctrl_rst | input | 1 | Synchronous reset, control domain, active high |
| reg_addr | input | ADDR_W | Register address: {stream, status-not-control} |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | REG_W | Read data, one cycle after the strobe |
| data_clk | input | 1 | Data path clock |
| data_rst | input | 1 | Synchronous reset, data domain, active high |
| in_valid | input | NUM_STREAMS | Per-stream word valid |
| in_data | input | NUM_STREAMS*DATA_W | Per-stream data words, stream s at bits s*DATA_W and up |

## Verification
The bound assertions check on every data clock edge the local rules that hold for each stream. A disabled stream holds no-result and no error. A raised error stays up while no re-arm occurs. A re-arm clears the flags and the seed. A seeding word never clears no-result. On the control clock they check that a status read returns zero upper bits. End-to-end outcomes can only be shown by the bench scenarios, because they depend on the data history and on both synchronizer crossings. These outcomes include match versus mismatch for each pattern, detection of a single low or upper corrupted word, the error still reading 1 hundreds of cycles later, isolation between streams, and an idle stream staying without a result.

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int NUM_STREAMS = 2,
  parameter int DATA_W      = 40,
  parameter int SEQ_W       = 32,
  parameter int REG_W       = 32,
  parameter logic [SEQ_W-1:0] TAPS = 32'h8020_0003,
  localparam int SIDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int ADDR_W = SIDX_W + 1
) (
  input  logic                          ctrl_clk,
  input  logic                          ctrl_rst,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_wr,
  input  logic [REG_W-1:0]              reg_wdata,
  input  logic                          reg_rd,
  output logic [REG_W-1:0]              reg_rdata,
  input  logic                          data_clk,
  input  logic                          data_rst,
  input  logic [NUM_STREAMS-1:0]        in_valid,
  input  logic [NUM_STREAMS*DATA_W-1:0] in_data
);

  logic [NUM_STREAMS-1:0][1:0] ctrl_q;
  logic [NUM_STREAMS-1:0][1:0] stat_s1, stat_s2;
  logic [NUM_STREAMS-1:0]      en_d, err_d, nores_d, seeded_d, restart_d;

  logic [SIDX_W-1:0] sidx;
  logic              sidx_ok;
  assign sidx    = reg_addr[ADDR_W-1:1];
  assign sidx_ok = int'(sidx) < NUM_STREAMS;

  always_ff @(posedge ctrl_clk) begin
    if (ctrl_rst) begin
      ctrl_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && !reg_addr[0] && sidx_ok)
        ctrl_q[sidx] <= reg_wdata[1:0];
      if (reg_rd) begin
        reg_rdata <= '0;
        if (sidx_ok)
          reg_rdata[1:0] <= reg_addr[0] ? stat_s2[sidx] : ctrl_q[sidx];
      end
    end
  end

  always_ff @(posedge ctrl_clk) begin
    if (ctrl_rst) begin
      stat_s1 <= {NUM_STREAMS{2'b10}};
      stat_s2 <= {NUM_STREAMS{2'b10}};
    end else begin
      for (int s = 0; s < NUM_STREAMS; s++)
        stat_s1[s] <= {nores_d[s], err_d[s]};
      stat_s2 <= stat_s1;
    end
  end

  function automatic logic [SEQ_W-1:0] step(input logic [SEQ_W-1:0] v, input logic cnt);
    return cnt ? v + 1'b1 : {v[SEQ_W-2:0], ^(v & TAPS)};
  endfunction

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_lane
    logic [1:0]        c_s1, c_s2;
    logic              en_q, sel_q, restart;
    logic              seeded, err, nores;
    logic [SEQ_W-1:0]  expv;
    logic [DATA_W-1:0] word, expw;

    assign word = in_data[g*DATA_W +: DATA_W];

    always_comb
      for (int b = 0; b < DATA_W; b++) expw[b] = expv[b % SEQ_W];

    assign restart = c_s2[0] && (!en_q || (c_s2[1] != sel_q));

    always_ff @(posedge data_clk) begin
      if (data_rst) begin
        c_s1  <= '0;
        c_s2  <= '0;
        en_q  <= 1'b0;
        sel_q <= 1'b0;
      end else begin
        c_s1  <= ctrl_q[g];
        c_s2  <= c_s1;
        en_q  <= c_s2[0];
        sel_q <= c_s2[1];
      end
    end

    always_ff @(posedge data_clk) begin
      if (data_rst || !c_s2[0] || restart) begin
        seeded <= 1'b0;
        err    <= 1'b0;
        nores  <= 1'b1;
        expv   <= '0;
      end else if (in_valid[g]) begin
        if (!seeded) begin
          seeded <= 1'b1;
          expv   <= step(word[SEQ_W-1:0], c_s2[1]);
        end else begin
          if (word != expw) err <= 1'b1;
          nores <= 1'b0;
          expv  <= step(expv, c_s2[1]);
        end
      end
    end

    assign en_d[g]      = c_s2[0];
    assign restart_d[g] = restart;
    assign err_d[g]     = err;
    assign nores_d[g]   = nores;
    assign seeded_d[g]  = seeded;
  end

endmodule

// File: rtl/seq_checker_props.sv
module seq_checker_props #(
  parameter int NS     = 2,
  parameter int ADDR_W = 2,
  parameter int REG_W  = 32
) (
  input logic              ctrl_clk,
  input logic              ctrl_rst,
  input logic              data_clk,
  input logic              data_rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NS-1:0]     in_valid,
  input logic [NS-1:0]     en_d,
  input logic [NS-1:0]     err_d,
  input logic [NS-1:0]     nores_d,
  input logic [NS-1:0]     seeded_d,
  input logic [NS-1:0]     restart_d
);

  a_r2_status_upper_zero: assert property (@(posedge ctrl_clk) disable iff (ctrl_rst)
    reg_rd && reg_addr[0] |=> reg_rdata[REG_W-1:2] == '0);

  for (genvar s = 0; s < NS; s++) begin : g_p
    a_r3_off_no_result: assert property (@(posedge data_clk) disable iff (data_rst)
      !en_d[s] |=> nores_d[s] && !err_d[s]);

    a_r7_err_sticky: assert property (@(posedge data_clk) disable iff (data_rst)
      err_d[s] && en_d[s] && !restart_d[s] |=> err_d[s]);

    a_r8_rearm_clears: assert property (@(posedge data_clk) disable iff (data_rst)
      restart_d[s] |=> !err_d[s] && nores_d[s] && !seeded_d[s]);

    a_r9_seed_no_compare: assert property (@(posedge data_clk) disable iff (data_rst)
      en_d[s] && !restart_d[s] && !seeded_d[s] && in_valid[s] |=> nores_d[s] && seeded_d[s]);
  end

endmodule

bind seq_checker seq_checker_props #(
  .NS(NUM_STREAMS), .ADDR_W(ADDR_W), .REG_W(REG_W)
) u_props (
  .ctrl_clk(ctrl_clk), .ctrl_rst(ctrl_rst), .data_clk(data_clk), .data_rst(data_rst),
  .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .in_valid(in_valid),
  .en_d(en_d), .err_d(err_d), .nores_d(nores_d), .seeded_d(seeded_d), .restart_d(restart_d)
);

// File: tb/seq_checker_bench.sv
`timescale 1ns/1ps
module seq_checker_bench;
  localparam int NS = 2, DW = 40, SW = 32, RW = 32, AW = 2;

  logic ctrl_clk = 0, data_clk = 0, ctrl_rst = 1, data_rst = 1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [RW-1:0] reg_wdata = '0, reg_rdata;
  logic [NS-1:0] in_valid = '0;
  logic [NS*DW-1:0] in_data = '0;

  always #4   ctrl_clk = ~ctrl_clk;
  always #2.5 data_clk = ~data_clk;

  seq_checker u_seq_checker (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NS-1:0] tx_en = '0, tx_sel = '0, f_lo = '0, f_hi = '0;
  logic [SW-1:0] tx_val [NS];

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] v, input logic cnt);
    if (cnt) return v + 32'd1;
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  function automatic logic [DW-1:0] repl(input logic [SW-1:0] v);
    logic [DW-1:0] w;
    for (int b = 0; b < DW; b++) w[b] = v[b % SW];
    return w;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < NS; s++) tx_val[s] = 32'd17;
    forever begin
      @(negedge data_clk);
      for (int s = 0; s < NS; s++) begin
        if (tx_en[s] && ($urandom % 4) != 0) begin
          logic [DW-1:0] w;
          w = repl(tx_val[s]);
          if (f_lo[s]) begin w[3] = ~w[3]; f_lo[s] = 0; end
          else if (f_hi[s]) begin w[SW] = ~w[SW]; f_hi[s] = 0; end
          in_valid[s] = 1'b1;
          in_data[s*DW +: DW] = w;
          tx_val[s] = nxt(tx_val[s], tx_sel[s]);
        end else in_valid[s] = 1'b0;
      end
    end
  end

  task automatic wr(input int a, input logic [RW-1:0] d);
    @(negedge ctrl_clk); reg_addr = AW'(a); reg_wdata = d; reg_wr = 1;
    @(negedge ctrl_clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [RW-1:0] d);
    @(negedge ctrl_clk); reg_addr = AW'(a); reg_rd = 1;
    @(negedge ctrl_clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic chk(input string tag, input logic [RW-1:0] got, input logic [RW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge ctrl_clk);
  endtask

  task automatic set_rx(input int s, input bit en, input bit sel);
    wr(2*s, {30'd0, sel, en});
    waitc(20);
  endtask

  task automatic set_tx(input int s, input bit sel, input logic [SW-1:0] seed);
    @(negedge ctrl_clk);
    tx_sel[s] = sel; tx_val[s] = seed; tx_en[s] = 1;
  endtask

  task automatic st(input int s, input string tag, input logic [1:0] exp);
    logic [RW-1:0] d;
    rd(2*s+1, d);
    chk(tag, d, {30'd0, exp});
  endtask

  initial begin
    logic [RW-1:0] d;
    waitc(5);
    ctrl_rst = 0; data_rst = 0;
    waitc(5);
    for (int s = 0; s < NS; s++) begin
      rd(2*s, d);   chk("R1 ctrl after reset", d, 0);
      st(s, "R3 status after reset", 2'b10);
    end
    wr(1, 32'hFFFF_FFFF);
    st(0, "R2 status write ignored", 2'b10);
    rd(0, d); chk("R2 ctrl untouched by status write", d, 0);
    wr(0, 32'hFFFF_FFF2);
    rd(0, d); chk("R1 ctrl upper bits dropped", d, 32'd2);
    set_rx(0, 0, 0);

    for (int s = 0; s < NS; s++) set_tx(s, 1, 32'd17);
    for (int s = 0; s < NS; s++) set_rx(s, 1, 1);
    waitc(60);
    for (int s = 0; s < NS; s++) st(s, "R4 R9 counter match", 2'b00);

    set_tx(0, 0, 32'd17);
    waitc(60);
    st(0, "R5 prbs data counter check", 2'b01);
    st(1, "R10 other stream clean", 2'b00);

    set_rx(0, 1, 0);
    waitc(60);
    st(0, "R8 R4 pattern change rearm prbs match", 2'b00);

    set_rx(0, 0, 0);
    st(0, "R3 disabled", 2'b10);

    set_rx(0, 1, 0);
    waitc(40);
    st(0, "R8 re-enable clean", 2'b00);
    f_lo[0] = 1;
    waitc(300);
    st(0, "R6 R7 low corruption sticky", 2'b01);
    st(1, "R10 stream 1 unaffected", 2'b00);

    set_rx(0, 0, 0);
    set_rx(0, 1, 0);
    waitc(40);
    st(0, "R8 rearm clears error", 2'b00);
    f_hi[0] = 1;
    waitc(300);
    st(0, "R6 R7 upper corruption sticky", 2'b01);

    @(negedge ctrl_clk); tx_en[1] = 0;
    set_rx(1, 0, 1);
    set_rx(1, 1, 1);
    waitc(60);
    st(1, "R9 no words no result", 2'b10);
    st(0, "R10 stream 0 keeps error", 2'b01);
    set_tx(1, 1, 32'hFFFF_FFFE);
    waitc(60);
    st(1, "R9 R4 counter wrap match", 2'b00);

    for (int it = 0; it < 8; it++) begin
      bit ts [NS];
      bit rs [NS];
      for (int s = 0; s < NS; s++) begin
        ts[s] = 1'($urandom);
        rs[s] = 1'($urandom);
        set_tx(s, ts[s], $urandom | 32'd1);
        set_rx(s, 0, 0);
        set_rx(s, 1, rs[s]);
      end
      waitc(60);
      for (int s = 0; s < NS; s++) begin
        rd(2*s, d); chk("R1 random ctrl readback", d, {30'd0, rs[s], 1'b1});
        st(s, (ts[s] == rs[s]) ? "R4 random match" : "R5 random mismatch",
           (ts[s] == rs[s]) ? 2'b00 : 2'b01);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ctrl_clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule